// File: doc/BRIEF.md
# Dual Page Table Address Translator

This block turns a 16-bit logical word address into a 24-bit physical word address. The lookup goes through one of sixteen page tables held in on-chip registers. A logical space holds 64K words, split into 64 pages of 1K words. The top six address bits pick an entry in the chosen table. The low ten bits pass straight through as the offset within the page. Each entry carries a valid flag and a 14-bit physical page number.

A paging control register names two tables, a normal one and an alternate one, and holds a two-bank mode flag. With the flag clear, every access is looked up in the normal table. With the flag set, the table depends on the access class. Instruction fetches and program-counter-relative references still use the normal table. All other data references use the alternate table. A program can then own two separate 64K-word spaces, one for code and one for data. An access whose entry is invalid raises a fault, and its physical address reads as zero.

The lookup itself is combinational. The result is registered, so each request is answered one cycle later. A small two-state machine tracks whether a result is present. In `ST_IDLE` no result is held. In `ST_RESULT` the registered result is valid for the request sampled at the previous edge. The transition `GO_RESULT` is taken on any edge where a request is present, from either state. The transition `GO_IDLE` is taken on any edge with no request, also from either state.

Top module: `dual_map_xlate`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_fault` and `rsp_paddr` are 0. The control register selects table 0 as both normal and alternate, with two-bank mode off. Every entry of every table is invalid, so the first access faults.
- R2: A request sampled on a rising edge gives `rsp_valid`=1 after that edge and up to the next one. An edge with no request leaves `rsp_valid`, `rsp_fault` and `rsp_paddr` all 0.
- R3: The entry index is `req_addr[15:10]` and the page offset is `req_addr[9:0]`. For a valid entry, `rsp_paddr` = {entry page number, offset}.
- R4: In one-bank mode (`pcr_wdata[8]`=0), every access class is looked up in the normal table.
- R5: In two-bank mode (`pcr_wdata[8]`=1), classes 2'b00 (fetch) and 2'b01 (PC-relative) use the normal table. Classes 2'b10 and 2'b11 (other data) use the alternate table.
- R6: A control write loads the normal-table field from `pcr_wdata[3:0]`, the alternate-table field from `pcr_wdata[7:4]` and the mode from `pcr_wdata[8]`. A request in the same cycle as the write still uses the old settings. The new settings apply from the next access. Without a write, the register holds.
- R7: An access whose selected entry is invalid gives `rsp_fault`=1 with `rsp_paddr`=0.
- R8: A table write stores `tw_valid` and `tw_ppn` at entry `tw_index` of table `tw_table` and changes no other entry. A request in the same cycle sees the old entry content. Writing `tw_valid`=0 makes the entry fault.
- R9: Each of the sixteen tables, 0 through 15, can be chosen as normal or alternate, and their contents are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A translation request is present this cycle |
| req_addr | input | 16 | Logical word address |
| req_class | input | 2 | Access class: 00 fetch, 01 PC-relative, 10/11 other data |
| pcr_we | input | 1 | Write enable for the paging control register |
| pcr_wdata | input | 9 | [3:0] normal table, [7:4] alternate table, [8] two-bank mode |
| tw_en | input | 1 | Table entry write enable |
| tw_table | input | 4 | Table number to write |
| tw_index | input | 6 | Entry index to write |
| tw_valid | input | 1 | Valid flag to store |
| tw_ppn | input | 14 | Physical page number to store |
| rsp_valid | output | 1 | Registered result is present |
| rsp_paddr | output | 24 | Physical word address, zero on fault or idle |
| rsp_fault | output | 1 | Selected entry was invalid |

## Verification
Normal and alternate are always loaded with different tables holding different page numbers. The resulting address therefore shows which table served each of the four access classes. This is done in one-bank mode and again in two-bank mode, which separates R4 from R5. The first and last entries are hit with all-zero and all-ones offsets, and table 15 is used. These expose a wrong index slice, offset slice or table decode. Two patterns change a control field or an entry in the same cycle as a request, and then repeat the request. The first response must carry the old result and the second the new one, which pins down the write-versus-read ordering.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'b00,
        ACC_PCREL  = 2'b01,
        ACC_DATA   = 2'b10,
        ACC_DATA_X = 2'b11
    } acc_class_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } rsp_state_e;

    function automatic logic is_program_ref(input logic [1:0] cls);
        return (cls == ACC_FETCH) || (cls == ACC_PCREL);
    endfunction

endpackage

// File: rtl/xlt_ctrl_reg.sv
module xlt_ctrl_reg #(
    parameter int TSEL_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [2*TSEL_W:0]   wdata,
    output logic [TSEL_W-1:0]   norm_sel,
    output logic [TSEL_W-1:0]   alt_sel,
    output logic                two_bank
);

    localparam int CTRL_W = 2 * TSEL_W + 1;

    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we) begin
            ctrl_q <= wdata;
        end
    end

    assign norm_sel = ctrl_q[TSEL_W-1:0];
    assign alt_sel  = ctrl_q[2*TSEL_W-1:TSEL_W];
    assign two_bank = ctrl_q[CTRL_W-1];

    // R6: the register keeps its value when no write is present
    p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(ctrl_q));

endmodule

// File: rtl/xlt_table_sel.sv
module xlt_table_sel #(
    parameter int TSEL_W = 4
) (
    input  logic [1:0]        cls,
    input  logic              two_bank,
    input  logic [TSEL_W-1:0] norm_sel,
    input  logic [TSEL_W-1:0] alt_sel,
    output logic [TSEL_W-1:0] tbl
);
    import xlt_pkg::*;

    always_comb begin
        if (two_bank && !is_program_ref(cls)) begin
            tbl = alt_sel;
        end else begin
            tbl = norm_sel;
        end
    end

endmodule

// File: rtl/xlt_page_store.sv
module xlt_page_store #(
    parameter int TSEL_W = 4,
    parameter int IDX_W  = 6,
    parameter int PPN_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TSEL_W-1:0] wr_tbl,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [TSEL_W-1:0] rd_tbl,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [PPN_W-1:0]  rd_ppn
);

    localparam int NUM_TBL = 1 << TSEL_W;
    localparam int NUM_ENT = 1 << IDX_W;
    localparam int DEPTH   = NUM_TBL * NUM_ENT;

    logic [NUM_ENT-1:0] vld_q [NUM_TBL];
    logic [PPN_W-1:0]   ppn_q [DEPTH];

    // valid flags are reset per table so every entry starts out faulting
    for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[g] <= '0;
            end else if (wr_en && (wr_tbl == TSEL_W'(g))) begin
                vld_q[g][wr_idx] <= wr_valid;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ppn_q[{wr_tbl, wr_idx}] <= wr_ppn;
        end
    end

    assign rd_valid = vld_q[rd_tbl][rd_idx];
    assign rd_ppn   = ppn_q[{rd_tbl, rd_idx}];

endmodule

// File: rtl/dual_map_xlate.sv
module dual_map_xlate #(
    parameter int LA_W   = 16,
    parameter int OFS_W  = 10,
    parameter int PPN_W  = 14,
    parameter int TSEL_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [LA_W-1:0]         req_addr,
    input  logic [1:0]              req_class,
    input  logic                    pcr_we,
    input  logic [2*TSEL_W:0]       pcr_wdata,
    input  logic                    tw_en,
    input  logic [TSEL_W-1:0]       tw_table,
    input  logic [LA_W-OFS_W-1:0]   tw_index,
    input  logic                    tw_valid,
    input  logic [PPN_W-1:0]        tw_ppn,
    output logic                    rsp_valid,
    output logic [PPN_W+OFS_W-1:0]  rsp_paddr,
    output logic                    rsp_fault
);
    import xlt_pkg::*;

    localparam int IDX_W = LA_W - OFS_W;
    localparam int PA_W  = PPN_W + OFS_W;

    logic [TSEL_W-1:0] norm_sel;
    logic [TSEL_W-1:0] alt_sel;
    logic              two_bank;
    logic [TSEL_W-1:0] cur_tbl;
    logic              ent_valid;
    logic [PPN_W-1:0]  ent_ppn;
    logic [IDX_W-1:0]  req_idx;
    logic [OFS_W-1:0]  req_ofs;

    rsp_state_e state_q, state_d;

    assign req_idx = req_addr[LA_W-1:OFS_W];
    assign req_ofs = req_addr[OFS_W-1:0];

    xlt_ctrl_reg #(.TSEL_W(TSEL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (pcr_we),
        .wdata    (pcr_wdata),
        .norm_sel (norm_sel),
        .alt_sel  (alt_sel),
        .two_bank (two_bank)
    );

    xlt_table_sel #(.TSEL_W(TSEL_W)) u_sel (
        .cls      (req_class),
        .two_bank (two_bank),
        .norm_sel (norm_sel),
        .alt_sel  (alt_sel),
        .tbl      (cur_tbl)
    );

    xlt_page_store #(
        .TSEL_W (TSEL_W),
        .IDX_W  (IDX_W),
        .PPN_W  (PPN_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tw_en),
        .wr_tbl   (tw_table),
        .wr_idx   (tw_index),
        .wr_valid (tw_valid),
        .wr_ppn   (tw_ppn),
        .rd_tbl   (cur_tbl),
        .rd_idx   (req_idx),
        .rd_valid (ent_valid),
        .rd_ppn   (ent_ppn)
    );

    // next-state logic: GO_RESULT on a request, GO_IDLE otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = req_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
        end else if (req_valid) begin
            rsp_fault <= !ent_valid;
            rsp_paddr <= ent_valid ? {ent_ppn, req_ofs} : PA_W'(0);
        end else begin
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
        end
    end

    assign rsp_valid = (state_q == ST_RESULT);

    // R2: a request is answered on the next cycle
    p_answer_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2: an empty cycle leaves the outputs quiet
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_paddr == '0));

    // R3: the page offset passes through unchanged
    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ent_valid) |=> (rsp_paddr[OFS_W-1:0] == $past(req_ofs)));

    // R7: a faulting access never presents an address
    p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_paddr == '0));

endmodule

// File: tb/test_dual_map_xlate.sv
module test_dual_map_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_class = '0;
    logic        pcr_we = 1'b0;
    logic [8:0]  pcr_wdata = '0;
    logic        tw_en = 1'b0;
    logic [3:0]  tw_table = '0;
    logic [5:0]  tw_index = '0;
    logic        tw_valid = 1'b0;
    logic [13:0] tw_ppn = '0;
    logic        rsp_valid;
    logic [23:0] rsp_paddr;
    logic        rsp_fault;

    int n_checks = 0;
    int n_fails  = 0;

    // shadow of the expected state, kept from the requirements
    logic        sh_v [16][64];
    logic [13:0] sh_p [16][64];
    logic [3:0]  sh_norm = '0;
    logic [3:0]  sh_alt = '0;
    logic        sh_mode = 1'b0;

    always #10 clk = ~clk;

    dual_map_xlate i_dual_map_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_class (req_class),
        .pcr_we    (pcr_we),
        .pcr_wdata (pcr_wdata),
        .tw_en     (tw_en),
        .tw_table  (tw_table),
        .tw_index  (tw_index),
        .tw_valid  (tw_valid),
        .tw_ppn    (tw_ppn),
        .rsp_valid (rsp_valid),
        .rsp_paddr (rsp_paddr),
        .rsp_fault (rsp_fault)
    );

    task automatic check(input string tag, input logic [25:0] act, input logic [25:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual valid/fault/paddr=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [25:0] model(input logic [15:0] a, input logic [1:0] c);
        logic [3:0] t;
        t = (sh_mode && c[1]) ? sh_alt : sh_norm;
        if (!sh_v[t][a[15:10]]) return {1'b1, 1'b1, 24'h0};
        return {1'b1, 1'b0, sh_p[t][a[15:10]], a[9:0]};
    endfunction

    task automatic put_entry(input logic [3:0] t, input logic [5:0] i, input logic v, input logic [13:0] p);
        @(negedge clk);
        tw_en = 1'b1; tw_table = t; tw_index = i; tw_valid = v; tw_ppn = p;
        @(negedge clk);
        tw_en = 1'b0;
        sh_v[t][i] = v; sh_p[t][i] = p;
    endtask

    task automatic put_ctrl(input logic [3:0] n, input logic [3:0] a, input logic m);
        @(negedge clk);
        pcr_we = 1'b1; pcr_wdata = {m, a, n};
        @(negedge clk);
        pcr_we = 1'b0;
        sh_norm = n; sh_alt = a; sh_mode = m;
    endtask

    task automatic access(input string tag, input logic [15:0] a, input logic [1:0] c);
        logic [25:0] e;
        e = model(a, c);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_class = c;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {rsp_valid, rsp_fault, rsp_paddr}, e);
    endtask

    task automatic t_reset;
        check("R1 reset outputs", {rsp_valid, rsp_fault, rsp_paddr}, 26'h0);
        access("R1 first access faults", 16'h1234, 2'b00);
        access("R1 data access faults", 16'hFC00, 2'b10);
    endtask

    task automatic t_idle;
        @(negedge clk);
        check("R2 idle outputs quiet", {rsp_valid, rsp_fault, rsp_paddr}, 26'h0);
    endtask

    task automatic t_fill;
        put_entry(4'd3, 6'd5,  1'b1, 14'h0A11);
        put_entry(4'd5, 6'd5,  1'b1, 14'h1B22);
        put_entry(4'd3, 6'd0,  1'b1, 14'h0001);
        put_entry(4'd3, 6'd63, 1'b1, 14'h3FFF);
        put_entry(4'd15, 6'd5, 1'b1, 14'h2C33);
    endtask

    task automatic t_onebank;
        put_ctrl(4'd3, 4'd5, 1'b0);
        for (int c = 0; c < 4; c++) begin
            access("R4 one-bank uses normal", 16'h1555, 2'(c));
        end
        access("R3 index 0 offset 0", 16'h0000, 2'b00);
        access("R3 index 63 offset 3FF", 16'hFFFF, 2'b01);
    endtask

    task automatic t_twobank;
        put_ctrl(4'd3, 4'd5, 1'b1);
        access("R5 fetch uses normal", 16'h1555, 2'b00);
        access("R5 pc-relative uses normal", 16'h17AA, 2'b01);
        access("R5 data uses alternate", 16'h1555, 2'b10);
        access("R5 data class 3 uses alternate", 16'h1401, 2'b11);
        access("R7 alternate entry invalid", 16'hFFFF, 2'b10);
    endtask

    task automatic t_table15;
        put_ctrl(4'd15, 4'd3, 1'b1);
        access("R9 table 15 as normal", 16'h1600, 2'b00);
        access("R9 table 3 as alternate", 16'h1600, 2'b11);
    endtask

    task automatic t_ctrl_timing;
        logic [25:0] e;
        e = model(16'h1500, 2'b00);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h1500; req_class = 2'b00;
        pcr_we = 1'b1; pcr_wdata = {1'b1, 4'd15, 4'd5};
        @(negedge clk);
        req_valid = 1'b0; pcr_we = 1'b0;
        check("R6 same-cycle control write unseen", {rsp_valid, rsp_fault, rsp_paddr}, e);
        sh_norm = 4'd5; sh_alt = 4'd15; sh_mode = 1'b1;
        access("R6 new normal field applies", 16'h1500, 2'b00);
        access("R6 new alternate field applies", 16'h1500, 2'b10);
    endtask

    task automatic t_entry_timing;
        logic [25:0] e;
        e = model(16'h14C0, 2'b00);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h14C0; req_class = 2'b00;
        tw_en = 1'b1; tw_table = 4'd5; tw_index = 6'd5; tw_valid = 1'b0; tw_ppn = 14'h0;
        @(negedge clk);
        req_valid = 1'b0; tw_en = 1'b0;
        check("R8 same-cycle entry write unseen", {rsp_valid, rsp_fault, rsp_paddr}, e);
        sh_v[5][5] = 1'b0; sh_p[5][5] = 14'h0;
        access("R8 invalidated entry faults", 16'h14C0, 2'b00);
        access("R7 invalid gives zero address", 16'h14C0, 2'b01);
        access("R8 other table untouched", 16'h14C0, 2'b10);
    endtask

    initial begin
        for (int t = 0; t < 16; t++) begin
            for (int i = 0; i < 64; i++) begin
                sh_v[t][i] = 1'b0;
                sh_p[t][i] = '0;
            end
        end
        repeat (3) @(negedge clk);
        t_reset_before_release();
        rst_n = 1'b1;
        t_reset;
        t_idle;
        t_fill;
        t_onebank;
        t_idle;
        t_twobank;
        t_table15;
        t_ctrl_timing;
        t_entry_timing;
        t_idle;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    task automatic t_reset_before_release;
        check("R1 outputs held in reset", {rsp_valid, rsp_fault, rsp_paddr}, 26'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule